// File: doc/BRIEF.md
# Program Counter and Return-Stack Sequencer

This block is the fetch-side sequencer of a small core with 12-bit instructions. It holds an 11-bit program counter and a two-entry hardware return stack, and it presents the address of the instruction being fetched in each cycle. The core's decoder feeds it one-cycle control pulses: an advance enable, a subroutine call, a return, and a taken bit-test skip. It also receives the 8-bit call literal and two page-select bits from the status register.

The pipeline has one stage. While one instruction executes, the next one is being fetched from `fetchAddr`. A call, a return or a taken skip makes that prefetched word useless. The sequencer then raises `flush` for the following cycle, and the core executes a NOP in place of that word. Each of these operations therefore costs two cycles. The call target is the literal in the low eight address bits and the two page bits in the top two address bits. Address bit 8 is forced to zero, so a subroutine entry can only lie in the lower half of a 512-word page.

Top module: `fetch_sequencer`

## Requirements
- R1: A synchronous active-high `rst` sets `fetchAddr` to RESET_VEC and `flush` to 0, and clears every stack entry to 0. A return issued before any call therefore goes to address 0.
- R2: In a cycle with `advance` high and `flush` low, where no call, no return and no skip is requested, `fetchAddr` rises by one modulo 2^11 at the next edge and `flush` is 0 afterwards. A skip whose condition is false is presented as `skipReq` low and behaves the same way.
- R3: While `advance` is low, `fetchAddr`, `flush` and the stack keep their values, whatever the request inputs carry.
- R4: A call loads `fetchAddr` with `pageSel[1]` in bit 10, `pageSel[0]` in bit 9, 0 in bit 8 and `callLit` in bits 7:0.
- R5: A call pushes the fetch address presented during the call cycle onto the stack top. That address is the call's own address plus one. The call also raises `flush` for the next cycle, so it takes two cycles.
- R6: A return loads `fetchAddr` with the stack top, pops the stack and raises `flush` for the next cycle.
- R7: The stack holds two entries. A push that finds it full discards the oldest entry. A pop moves the lower entry up and leaves the bottom entry unchanged, so a third return after three nested calls goes again to the second call's return address.
- R8: A taken skip (`skipReq` high) advances `fetchAddr` by one and raises `flush` for the next cycle.
- R9: In a cycle with `flush` high and `advance` high, `callReq`, `retReq` and `skipReq` are ignored. `fetchAddr` rises by one and `flush` returns to 0.
- R10: When several requests arrive together in a cycle without flush, call wins over return, and return wins over skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Cycle enable; low stalls the sequencer |
| callReq | input | 1 | Executing instruction is a subroutine call |
| retReq | input | 1 | Executing instruction is a return |
| skipReq | input | 1 | Executing bit-test skip has its condition true |
| callLit | input | 8 | Call literal, becomes address bits 7:0 |
| pageSel | input | 2 | Page bits from the status register, become address bits 10:9 |
| fetchAddr | output | 11 | Address of the instruction fetched this cycle |
| flush | output | 1 | The instruction now executing must be replaced by a NOP |

## Verification
The bench keeps the default widths and stack depth of two. It sets RESET_VEC to 0x7FE, so the counter wraps from 0x7FF to 0x000 within the first two advances after reset. Because the stack has only two entries, three nested calls are enough to reach the overwrite of the oldest entry and the repeated bottom entry on the third return. Calls are issued with all four page settings, including a literal of 0xFF, which shows that bit 8 stays clear.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  // One-hot-or-idle strobes from the control to the datapath.
  typedef struct packed {
    logic incPc;
    logic loadCall;
    logic loadRet;
  } seqStrobe_t;

endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       advance,
  input  logic       callReq,
  input  logic       retReq,
  input  logic       skipReq,
  output seqStrobe_t strb,
  output logic       flush
);

  logic flushQ;
  logic redirect;

  // Any request that makes the prefetched word useless.
  assign redirect = callReq | retReq | skipReq;

  // Priority: a pending flush masks everything, then call, return, skip/increment.
  always_comb begin
    strb = '0;
    if (advance) begin
      if (flushQ)       strb.incPc    = 1'b1;
      else if (callReq) strb.loadCall = 1'b1;
      else if (retReq)  strb.loadRet  = 1'b1;
      else              strb.incPc    = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          flushQ <= 1'b0;
    else if (advance) flushQ <= !flushQ && redirect;
  end

  assign flush = flushQ;

  AST_CALL_FLUSHES: assert property (@(posedge clk) disable iff (rst)
    (advance && !flushQ && callReq) |=> flushQ);                        // R5
  AST_SKIP_FLUSHES: assert property (@(posedge clk) disable iff (rst)
    (advance && !flushQ && skipReq) |=> flushQ);                        // R8
  AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (advance && flushQ) |=> !flushQ);                                   // R9
  AST_STALL_KEEPS_FLUSH: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(flushQ));                                      // R3

endmodule

// File: rtl/fseq_dp.sv
module fseq_dp
  import fseq_pkg::*;
#(
  parameter int              PC_W      = 11,
  parameter int              LIT_W     = 8,
  parameter int              PAGE_W    = 2,
  parameter int              DEPTH     = 2,
  parameter logic [PC_W-1:0] RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strb,
  input  logic [LIT_W-1:0]  callLit,
  input  logic [PAGE_W-1:0] pageSel,
  output logic [PC_W-1:0]   pcOut
);

  localparam int              GAP_W = PC_W - LIT_W - PAGE_W;
  localparam logic [PC_W-1:0] ONE   = PC_W'(1);

  logic [PC_W-1:0] pcQ;
  logic [PC_W-1:0] callTarget;
  logic [PC_W-1:0] stk [DEPTH];

  // Page bits on top, forced-zero gap, literal at the bottom.
  assign callTarget = {pageSel, {GAP_W{1'b0}}, callLit};

  always_ff @(posedge clk) begin
    if (rst)                pcQ <= RESET_VEC;
    else if (strb.loadCall) pcQ <= callTarget;
    else if (strb.loadRet)  pcQ <= stk[0];
    else if (strb.incPc)    pcQ <= pcQ + ONE;
  end

  // Return stack: entry 0 is the top. Push shifts down, pop shifts up.
  for (genvar i = 0; i < DEPTH; i++) begin : g_stk
    logic [PC_W-1:0] pushVal;
    logic [PC_W-1:0] popVal;
    if (i == 0) begin : g_top
      assign pushVal = pcQ;
    end else begin : g_lower
      assign pushVal = stk[i-1];
    end
    if (i == DEPTH - 1) begin : g_bottom
      assign popVal = stk[i];
    end else begin : g_upper
      assign popVal = stk[i+1];
    end
    always_ff @(posedge clk) begin
      if (rst)                stk[i] <= '0;
      else if (strb.loadCall) stk[i] <= pushVal;
      else if (strb.loadRet)  stk[i] <= popVal;
    end
  end

  assign pcOut = pcQ;

  AST_CALL_BIT8_LOW: assert property (@(posedge clk) disable iff (rst)
    strb.loadCall |=> pcQ[LIT_W] == 1'b0);                              // R4
  AST_CALL_PAGE: assert property (@(posedge clk) disable iff (rst)
    strb.loadCall |=> pcQ[PC_W-1 -: PAGE_W] == $past(pageSel));         // R4
  AST_PUSH_RETADDR: assert property (@(posedge clk) disable iff (rst)
    strb.loadCall |=> stk[0] == $past(pcQ));                            // R5
  AST_RET_TARGET: assert property (@(posedge clk) disable iff (rst)
    strb.loadRet |=> pcQ == $past(stk[0]));                             // R6
  AST_INC_WRAP: assert property (@(posedge clk) disable iff (rst)
    strb.incPc |=> pcQ == $past(pcQ) + ONE);                            // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (strb == '0) |=> $stable(pcQ) && $stable(stk[0]));                  // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb));                                                    // R10

endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer
  import fseq_pkg::*;
#(
  parameter int              PC_W      = 11,
  parameter int              LIT_W     = 8,
  parameter int              PAGE_W    = 2,
  parameter int              DEPTH     = 2,
  parameter logic [PC_W-1:0] RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic              callReq,
  input  logic              retReq,
  input  logic              skipReq,
  input  logic [LIT_W-1:0]  callLit,
  input  logic [PAGE_W-1:0] pageSel,
  output logic [PC_W-1:0]   fetchAddr,
  output logic              flush
);

  seqStrobe_t strb;

  fseq_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .advance (advance),
    .callReq (callReq),
    .retReq  (retReq),
    .skipReq (skipReq),
    .strb    (strb),
    .flush   (flush)
  );

  fseq_dp #(
    .PC_W      (PC_W),
    .LIT_W     (LIT_W),
    .PAGE_W    (PAGE_W),
    .DEPTH     (DEPTH),
    .RESET_VEC (RESET_VEC)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .callLit (callLit),
    .pageSel (pageSel),
    .pcOut   (fetchAddr)
  );

endmodule

// File: tb/fetch_sequencer_tb.sv
module fetch_sequencer_tb;

  localparam int              PC_W   = 11;
  localparam int              LIT_W  = 8;
  localparam int              PAGE_W = 2;
  localparam int              DEPTH  = 2;
  localparam logic [PC_W-1:0] RV     = 11'h7FE;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              advance = 1'b0, callReq = 1'b0, retReq = 1'b0, skipReq = 1'b0;
  logic [LIT_W-1:0]  callLit = '0;
  logic [PAGE_W-1:0] pageSel = '0;
  logic [PC_W-1:0]   fetchAddr;
  logic              flush;

  always #5 clk = ~clk;

  fetch_sequencer #(
    .PC_W(PC_W), .LIT_W(LIT_W), .PAGE_W(PAGE_W), .DEPTH(DEPTH), .RESET_VEC(RV)
  ) u_dut (
    .clk(clk), .rst(rst), .advance(advance), .callReq(callReq), .retReq(retReq),
    .skipReq(skipReq), .callLit(callLit), .pageSel(pageSel),
    .fetchAddr(fetchAddr), .flush(flush)
  );

  int nChecks = 0;
  int nFails  = 0;

  // Behavioural reference: integer PC, bit flush, queue stack (front = top).
  int mPc;
  bit mFlush;
  int mStk[$];

  task automatic modelReset();
    mPc = int'(RV);
    mFlush = 1'b0;
    mStk.delete();
    repeat (DEPTH) mStk.push_back(0);
  endtask

  task automatic modelStep(bit a, bit c, bit r, bit s, int lit, int pg);
    if (!a) return;
    if (mFlush) begin
      mPc = (mPc + 1) % (2 ** PC_W);
      mFlush = 1'b0;
    end else if (c) begin
      mStk.push_front(mPc);
      void'(mStk.pop_back());
      mPc = pg * (2 ** (PC_W - PAGE_W)) + lit;
      mFlush = 1'b1;
    end else if (r) begin
      mPc = mStk.pop_front();
      mStk.push_back(mStk[$]);
      mFlush = 1'b1;
    end else begin
      mPc = (mPc + 1) % (2 ** PC_W);
      mFlush = s;
    end
  endtask

  task automatic check(string tag);
    nChecks++;
    if (fetchAddr !== PC_W'(mPc) || flush !== mFlush) begin
      nFails++;
      $display("FAIL %s: fetchAddr=%h flush=%b, expected fetchAddr=%h flush=%b",
               tag, fetchAddr, flush, PC_W'(mPc), mFlush);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, compare at the next falling edge.
  task automatic step(bit a, bit c, bit r, bit s, int lit, int pg, string tag);
    advance = a; callReq = c; retReq = r; skipReq = s;
    callLit = LIT_W'(lit); pageSel = PAGE_W'(pg);
    @(posedge clk);
    modelStep(a, c, r, s, lit, pg);
    @(negedge clk);
    check(tag);
  endtask

  task automatic doReset();
    rst = 1'b1;
    advance = 1'b0; callReq = 1'b0; retReq = 1'b0; skipReq = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    modelReset();
    check("R1 reset state");
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    doReset();

    // R2: increments and wrap from 0x7FF to 0x000
    step(1, 0, 0, 0, 0, 0, "R2 inc");
    step(1, 0, 0, 0, 0, 0, "R2 wrap");
    step(1, 0, 0, 0, 0, 0, "R2 inc");
    // R1: return on the emptied stack goes to 0
    step(1, 0, 1, 0, 0, 0, "R1 empty-stack return");
    // R9: requests during flush are ignored
    step(1, 1, 1, 1, 8'h55, 3, "R9 flush masks requests");
    // R3: stall holds everything
    step(0, 1, 0, 0, 8'h12, 1, "R3 stall with call");
    step(0, 0, 1, 1, 0, 0, "R3 stall with ret/skip");

    // R4/R5/R6: calls with each page setting, then return
    for (int pg = 0; pg < 4; pg++) begin
      step(1, 1, 0, 0, (pg == 3) ? 8'hFF : 8'hA5 - pg, pg, "R4 call target");
      step(0, 0, 0, 0, 0, 0, "R3 stall holds flush");
      step(1, 0, 0, 0, 0, 0, "R5 call flush cycle");
      step(1, 0, 0, 0, 0, 0, "R2 inc in subroutine");
      step(1, 0, 1, 0, 0, 0, "R6 return");
      step(1, 0, 0, 0, 0, 0, "R9 return flush cycle");
    end

    // R7: three nested calls, then three returns
    step(1, 1, 0, 0, 8'h10, 0, "R5 nested call 1");
    step(1, 0, 0, 0, 0, 0, "R5 flush");
    step(1, 1, 0, 0, 8'h20, 1, "R5 nested call 2");
    step(1, 0, 0, 0, 0, 0, "R5 flush");
    step(1, 1, 0, 0, 8'h30, 2, "R7 nested call 3 overwrites oldest");
    step(1, 0, 0, 0, 0, 0, "R5 flush");
    step(1, 0, 1, 0, 0, 0, "R7 return 1");
    step(1, 0, 0, 0, 0, 0, "R9 flush");
    step(1, 0, 1, 0, 0, 0, "R7 return 2");
    step(1, 0, 0, 0, 0, 0, "R9 flush");
    step(1, 0, 1, 0, 0, 0, "R7 return 3 repeats bottom");
    step(1, 0, 0, 0, 0, 0, "R9 flush");

    // R8: taken skip, skip during flush, not-taken skip
    step(1, 0, 0, 1, 0, 0, "R8 taken skip");
    step(1, 0, 0, 1, 0, 0, "R9 skip ignored in flush");
    step(1, 0, 0, 0, 0, 0, "R2 not-taken skip");
    step(0, 0, 0, 1, 0, 0, "R3 stalled skip");

    // R10: priority call > ret > skip
    step(1, 1, 1, 1, 8'h44, 2, "R10 call wins");
    step(1, 0, 0, 0, 0, 0, "R9 flush");
    step(1, 0, 1, 1, 0, 0, "R10 ret beats skip");
    step(1, 0, 0, 0, 0, 0, "R9 flush");

    // R1: reset in mid-run empties the stack
    step(1, 1, 0, 0, 8'h77, 1, "R4 call before reset");
    @(negedge clk);
    doReset();
    step(1, 0, 1, 0, 0, 0, "R1 return after reset");
    step(1, 0, 0, 0, 0, 0, "R9 flush");

    finishRun();
  end

  initial begin
    #2_000_000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog (all requirements): actual=hung expected=complete");
    finishRun();
  end

endmodule